// File: doc/BRIEF.md
# PIO Cycle Timing Generator

This block produces the strobe timing of one programmed-I/O transfer on a disk-interface bus. A cycle has three phases in a fixed order. First comes an address setup interval with no strobe. Next the command strobe is active, either the read strobe or the write strobe. Last comes a recovery interval with no strobe. Each phase lasts a number of clocks set by software-programmed timing values. Every drive has its own values, and reads and writes use different ones.

Each drive supplies three values: a read timing byte, a write timing byte and a small setup count. In a timing byte the low nibble is the recovery count and the high nibble is the strobe pulse count. A start request arrives with a direction and a drive index. At that moment the block latches the matching byte and setup count and then runs the cycle by itself. The programmed values come from mode tables that depend on the bus clock rate. At 33 MHz the pulse counts for modes 0 to 4 are 5, 4, 3, 2 and 2, the recovery counts are 9, 4, 0, 0 and 0, and the setup counts are 2, 1, 1, 1 and 0. At 25 MHz the same modes use pulse 4, 3, 2, 2, 1, recovery 6, 2, 0, 0, 0 and setup 1, 1, 0, 0, 0.

Top module: `pio_cycle_timer`

## Requirements
- R1: While reset is held (synchronous, active low) and in the cycle after it, `busy_o`, `done_o`, `rd_strobe_o` and `wr_strobe_o` are all 0.
- R2: A start request seen at a clock edge while `busy_o` is 0 raises `busy_o` from the next cycle. The setup phase then lasts max(S,1) cycles with both strobes low. S is the drive's 2-bit setup count, taken from `setup_i[2*d +: 2]` for drive d.
- R3: After setup, the strobe phase lasts max(P,1) cycles. P is bits 7:4 of the selected timing byte.
- R4: After the strobe phase, the recovery phase lasts max(Q,1) cycles with both strobes low and `busy_o` high. Q is bits 3:0 of the selected timing byte.
- R5: When `rd_not_wr_i` is 1 the cycle uses the read byte and asserts only `rd_strobe_o`. When it is 0 the cycle uses the write byte and asserts only `wr_strobe_o`.
- R6: The drive index d selects the bytes `rd_timing_i[8*d +: 8]` and `wr_timing_i[8*d +: 8]` and the setup field `setup_i[2*d +: 2]`.
- R7: A programmed count of 0 still gives a phase of one cycle.
- R8: A start request seen while `busy_o` is 1 has no effect on the cycle in progress and does not start a new one.
- R9: `done_o` is high for exactly one cycle, the first cycle after recovery, with `busy_o` low. A start seen in that cycle is accepted.
- R10: Direction, drive index and timing inputs are sampled only when a start is accepted. Changes to them during a cycle do not alter it.
- R11: `rd_strobe_o` and `wr_strobe_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request one transfer cycle |
| rd_not_wr_i | input | 1 | Direction: 1 read, 0 write |
| drive_i | input | 1 | Drive index |
| rd_timing_i | input | 16 | Read timing byte per drive, drive d at bits 8d+7:8d |
| wr_timing_i | input | 16 | Write timing byte per drive, same layout |
| setup_i | input | 4 | Setup count per drive, drive d at bits 2d+1:2d |
| rd_strobe_o | output | 1 | Read command strobe, active high |
| wr_strobe_o | output | 1 | Write command strobe, active high |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-clock pulse after recovery ends |

## Verification
Several properties are checked by assertions on every cycle:
- the two strobes never overlap;
- a strobe appears only while busy and never in the first busy cycle;
- busy rises only after a start request;
- done is a single-cycle pulse that comes right after busy falls;
- reset leaves the outputs quiet.

The exact phase lengths cannot be seen from the ports alone. Nor can it be shown that the correct drive and direction were used, or that inputs changed mid-cycle or a start seen while busy are ignored. Those are shown only by the bench's reference model, which is compared every cycle across its scenarios: the mode-table values, zero and maximum counts, both drives and both directions, and back-to-back starts.

// File: rtl/pio_timer_pkg.sv
// Package: shared phase encoding and field layout for the PIO cycle timer.
// Assumes a timing byte made of two equal-width count fields.
package pio_timer_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_RECOV = 2'd3
    } phase_t;
endpackage

// File: rtl/pio_timing_sel.sv
// Module: pio_timing_sel
// Picks the setup, pulse and recovery counts for one drive and direction
// from flattened per-drive timing vectors. Purely combinational.
// Assumes NUM_DRV >= 2 and a timing byte of {pulse, recovery} fields.
module pio_timing_sel #(
    parameter int NUM_DRV = 2,
    parameter int SETUP_W = 2,
    parameter int FIELD_W = 4,
    localparam int TIM_W  = 2 * FIELD_W,
    localparam int IDX_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input  logic [IDX_W-1:0]           drive_sel,
    input  logic                       dir_rd,
    input  logic [NUM_DRV*TIM_W-1:0]   rd_tim_flat,
    input  logic [NUM_DRV*TIM_W-1:0]   wr_tim_flat,
    input  logic [NUM_DRV*SETUP_W-1:0] setup_flat,
    output logic [SETUP_W-1:0]         setup_cnt,
    output logic [FIELD_W-1:0]         pulse_cnt,
    output logic [FIELD_W-1:0]         recov_cnt
);
    logic [TIM_W-1:0]   rd_arr    [NUM_DRV];
    logic [TIM_W-1:0]   wr_arr    [NUM_DRV];
    logic [SETUP_W-1:0] setup_arr [NUM_DRV];
    logic [TIM_W-1:0]   tim_byte;

    // Unpack the flattened per-drive vectors into arrays.
    for (genvar d = 0; d < NUM_DRV; d++) begin : g_unpack
        assign rd_arr[d]    = rd_tim_flat[d*TIM_W +: TIM_W];
        assign wr_arr[d]    = wr_tim_flat[d*TIM_W +: TIM_W];
        assign setup_arr[d] = setup_flat[d*SETUP_W +: SETUP_W];
    end

    // Select the byte for the requested direction and split its fields.
    always_comb begin
        tim_byte  = dir_rd ? rd_arr[drive_sel] : wr_arr[drive_sel];
        setup_cnt = setup_arr[drive_sel];
        pulse_cnt = tim_byte[TIM_W-1:FIELD_W];
        recov_cnt = tim_byte[FIELD_W-1:0];
    end
endmodule

// File: rtl/pio_tick_counter.sv
// Module: pio_tick_counter
// Loadable down-counter that flags the final cycle of a phase.
// Loading N yields N+1 cycles before the next load is due.
module pio_tick_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - {{(W-1){1'b0}}, 1'b1};
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/pio_phase_seq.sv
// Module: pio_phase_seq
// Sequences setup, strobe and recovery phases for one transfer.
// It latches the direction and the counts when a start is accepted in
// idle, and pulses done for one clock after recovery.
// Assumes the selected counts are valid in the cycle start is high.
module pio_phase_seq
    import pio_timer_pkg::*;
#(
    parameter int SETUP_W = 2,
    parameter int FIELD_W = 4,
    localparam int CNT_W  = (SETUP_W > FIELD_W) ? SETUP_W : FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               dir_rd,
    input  logic [SETUP_W-1:0] setup_cnt,
    input  logic [FIELD_W-1:0] pulse_cnt,
    input  logic [FIELD_W-1:0] recov_cnt,
    output logic               busy,
    output logic               rd_stb,
    output logic               wr_stb,
    output logic               done
);
    phase_t             phase;
    logic               dir_q;
    logic [FIELD_W-1:0] pulse_q;
    logic [FIELD_W-1:0] recov_q;
    logic               done_q;
    logic               accept;
    logic               last;
    logic               load;
    logic [CNT_W-1:0]   load_val;

    // Phase length minus one, with a zero count treated as one cycle.
    function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] n);
        return (n == '0) ? '0 : n - {{(CNT_W-1){1'b0}}, 1'b1};
    endfunction

    assign accept = start && (phase == PH_IDLE);

    // Decide when the counter reloads and with which phase length.
    always_comb begin
        load     = 1'b0;
        load_val = '0;
        if (accept) begin
            load     = 1'b1;
            load_val = len_m1(CNT_W'(setup_cnt));
        end else if (last && phase == PH_SETUP) begin
            load     = 1'b1;
            load_val = len_m1(CNT_W'(pulse_q));
        end else if (last && phase == PH_PULSE) begin
            load     = 1'b1;
            load_val = len_m1(CNT_W'(recov_q));
        end
    end

    pio_tick_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    // Phase state, latched cycle parameters and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            dir_q   <= 1'b0;
            pulse_q <= '0;
            recov_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase   <= PH_SETUP;
                    dir_q   <= dir_rd;
                    pulse_q <= pulse_cnt;
                    recov_q <= recov_cnt;
                end
                PH_SETUP: if (last) phase <= PH_PULSE;
                PH_PULSE: if (last) phase <= PH_RECOV;
                PH_RECOV: if (last) begin
                    phase  <= PH_IDLE;
                    done_q <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy   = (phase != PH_IDLE);
    assign rd_stb = (phase == PH_PULSE) &&  dir_q;
    assign wr_stb = (phase == PH_PULSE) && !dir_q;
    assign done   = done_q;
endmodule

// File: rtl/pio_cycle_timer.sv
// Module: pio_cycle_timer (top)
// Generates one programmed-I/O cycle per accepted start, using the
// per-drive read or write timing chosen by the drive index and direction.
// Assumes inputs are synchronous to clk.
module pio_cycle_timer #(
    parameter int NUM_DRV = 2,
    parameter int SETUP_W = 2,
    parameter int FIELD_W = 4,
    localparam int TIM_W  = 2 * FIELD_W,
    localparam int IDX_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       rd_not_wr_i,
    input  logic [IDX_W-1:0]           drive_i,
    input  logic [NUM_DRV*TIM_W-1:0]   rd_timing_i,
    input  logic [NUM_DRV*TIM_W-1:0]   wr_timing_i,
    input  logic [NUM_DRV*SETUP_W-1:0] setup_i,
    output logic                       rd_strobe_o,
    output logic                       wr_strobe_o,
    output logic                       busy_o,
    output logic                       done_o
);
    logic [SETUP_W-1:0] sel_setup;
    logic [FIELD_W-1:0] sel_pulse;
    logic [FIELD_W-1:0] sel_recov;

    pio_timing_sel #(
        .NUM_DRV (NUM_DRV),
        .SETUP_W (SETUP_W),
        .FIELD_W (FIELD_W)
    ) u_sel (
        .drive_sel   (drive_i),
        .dir_rd      (rd_not_wr_i),
        .rd_tim_flat (rd_timing_i),
        .wr_tim_flat (wr_timing_i),
        .setup_flat  (setup_i),
        .setup_cnt   (sel_setup),
        .pulse_cnt   (sel_pulse),
        .recov_cnt   (sel_recov)
    );

    pio_phase_seq #(
        .SETUP_W (SETUP_W),
        .FIELD_W (FIELD_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .dir_rd    (rd_not_wr_i),
        .setup_cnt (sel_setup),
        .pulse_cnt (sel_pulse),
        .recov_cnt (sel_recov),
        .busy      (busy_o),
        .rd_stb    (rd_strobe_o),
        .wr_stb    (wr_strobe_o),
        .done      (done_o)
    );
endmodule

// File: rtl/pio_cycle_timer_chk.sv
// Module: pio_cycle_timer_chk
// Protocol checks on the timer's ports, bound into every instance.
module pio_cycle_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic rd_strobe_o,
    input logic wr_strobe_o,
    input logic busy_o,
    input logic done_o
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !rd_strobe_o && !wr_strobe_o)); // R1

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R2

    AST_SETUP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!rd_strobe_o && !wr_strobe_o)); // R2

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_o || wr_strobe_o) |-> busy_o); // R3

    AST_MIN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_strobe_o || wr_strobe_o) |-> $past(busy_o)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R9

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe_o && wr_strobe_o)); // R11
endmodule

bind pio_cycle_timer pio_cycle_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rd_strobe_o (rd_strobe_o),
    .wr_strobe_o (wr_strobe_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/pio_cycle_timer_test.sv
// Bench: behavioural per-cycle reference model compared on every falling edge.
module pio_cycle_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_not_wr_i = 1'b0;
    logic        drive_i = 1'b0;
    logic [15:0] rd_timing_i = '0;
    logic [15:0] wr_timing_i = '0;
    logic [3:0]  setup_i = '0;
    logic        rd_strobe_o, wr_strobe_o, busy_o, done_o;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Expected outputs, encoded {busy, rd_strobe, wr_strobe, done}.
    logic [3:0] exp_q[$];
    logic [3:0] cur = 4'b0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_cycle_timer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .rd_not_wr_i (rd_not_wr_i),
        .drive_i     (drive_i),
        .rd_timing_i (rd_timing_i),
        .wr_timing_i (wr_timing_i),
        .setup_i     (setup_i),
        .rd_strobe_o (rd_strobe_o),
        .wr_strobe_o (wr_strobe_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    // Reference model: on an accepted start, queue the whole cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            cur = 4'b0000;
        end else begin
            if (!cur[3] && start_i) begin
                int tb, s, p, q;
                tb = rd_not_wr_i ? rd_timing_i[drive_i*8 +: 8] : wr_timing_i[drive_i*8 +: 8];
                s  = setup_i[drive_i*2 +: 2];
                p  = tb / 16;
                q  = tb % 16;
                if (s == 0) s = 1;
                if (p == 0) p = 1;
                if (q == 0) q = 1;
                for (int i = 0; i < s; i++) exp_q.push_back(4'b1000);
                for (int i = 0; i < p; i++)
                    exp_q.push_back(rd_not_wr_i ? 4'b1100 : 4'b1010);
                for (int i = 0; i < q; i++) exp_q.push_back(4'b1000);
                exp_q.push_back(4'b0001);
            end
            cur = (exp_q.size() > 0) ? exp_q.pop_front() : 4'b0000;
        end
    end

    // Compare the outputs against the model away from the rising edge.
    always @(negedge clk) begin
        logic [3:0] got;
        got = {busy_o, rd_strobe_o, wr_strobe_o, done_o};
        vectors++;
        if (got !== cur) begin
            fails++;
            $display("FAIL %s: cycle %0d got busy/rd/wr/done=%b expected %b",
                     cur_req, cycles, got, cur);
        end
    end

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected <= %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic kick(input string req, input logic rd, input logic drv);
        cur_req     = req;
        rd_not_wr_i = rd;
        drive_i     = drv;
        start_i     = 1'b1;
        @(negedge clk);
        start_i     = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state held for several cycles.
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R2 R3 R4 R5: drive 0 read, 33 MHz mode 0 (setup 2, pulse 5, recovery 9).
        rd_timing_i[7:0] = 8'h59;
        wr_timing_i[7:0] = 8'h23;
        setup_i[1:0]     = 2'd2;
        kick("R2 R3 R4 R5 read mode0", 1'b1, 1'b0);
        idle(40);

        // R5: drive 0 write uses the write byte (pulse 2, recovery 3).
        kick("R5 write byte", 1'b0, 1'b0);
        idle(40);

        // R6: drive 1, 25 MHz mode 1 read (setup 1, pulse 3, recovery 2), then write.
        rd_timing_i[15:8] = 8'h32;
        wr_timing_i[15:8] = 8'h46;
        setup_i[3:2]      = 2'd1;
        kick("R6 drive1 read", 1'b1, 1'b1);
        idle(40);
        kick("R6 drive1 write", 1'b0, 1'b1);
        idle(40);

        // R7: all-zero counts give one-cycle phases; 25 MHz mode 4 has recovery 0.
        rd_timing_i[7:0] = 8'h00;
        setup_i[1:0]     = 2'd0;
        kick("R7 zero counts", 1'b1, 1'b0);
        idle(10);
        rd_timing_i[7:0] = 8'h10;
        kick("R7 mode4 25MHz", 1'b1, 1'b0);
        idle(10);

        // R8: starts while busy are ignored.
        wr_timing_i[7:0] = 8'hFF;
        setup_i[1:0]     = 2'd3;
        kick("R8 long write", 1'b0, 1'b0);
        idle(2);
        kick("R8 start in setup", 1'b1, 1'b1);
        idle(5);
        kick("R8 start in pulse", 1'b1, 1'b0);
        idle(15);
        kick("R8 start in recovery", 1'b1, 1'b1);
        idle(40);

        // R10: inputs changed mid-cycle do not alter the running cycle.
        rd_timing_i[7:0] = 8'h44;
        setup_i[1:0]     = 2'd2;
        kick("R10 sampled at start", 1'b1, 1'b0);
        rd_not_wr_i      = 1'b0;
        drive_i          = 1'b1;
        rd_timing_i      = 16'hFFFF;
        wr_timing_i      = 16'h1111;
        setup_i          = 4'hF;
        idle(40);

        // R9: held start restarts in the done cycle, back to back.
        rd_timing_i[7:0] = 8'h21;
        setup_i[1:0]     = 2'd1;
        cur_req          = "R9 back to back";
        rd_not_wr_i      = 1'b1;
        drive_i          = 1'b0;
        start_i          = 1'b1;
        idle(25);
        start_i          = 1'b0;
        idle(10);

        // R11 R3 R4: maximum counts on a read (setup 3, pulse 15, recovery 15).
        rd_timing_i[15:8] = 8'hFF;
        setup_i[3:2]      = 2'd3;
        kick("R3 R4 R11 max counts", 1'b1, 1'b1);
        idle(40);

        // R1: reset asserted in mid-cycle clears everything.
        kick("R1 reset mid-cycle", 1'b1, 1'b1);
        idle(6);
        cur_req = "R1 reset mid-cycle";
        rst_n   = 1'b0;
        idle(3);
        rst_n   = 1'b1;
        idle(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule